// File: doc/BRIEF.md
# PPM pulse train generator

This block drives a single pulse-position-modulated line from a list of pulse periods supplied by a host. A prescaler divides the system clock down to a 0.5 us tick. Within every pulse, a tick counter runs from zero up to that pulse's period. The line sits at its inactive level until the count reaches a delay compare value, and at its active level from there to the end of the pulse. The compare value is twice the configured delay, and it is frozen for a whole train. When a pulse ends, the period of the next one is taken from the next list entry. The final entry carries the inter-frame gap.

The host writes period words into whichever of two banks is not being played, then commits an entry count. At the end of the last entry of the train now playing, the generator switches to the committed bank. If nothing has been committed by then, the last entry plays again, so the line keeps a regular gap pattern and never glitches. A one-clock frame request is raised a fixed lead time before the last entry ends, which gives the host time to prepare and commit the next train.

When the run input rises, the generator first plays a fixed start interval. During this interval the line is held at its idle level, and a frame request is raised at a fixed tick of the interval. A polarity input selects which line level counts as active.

Top module: `ppm_train_gen`

## Requirements
- R1: With run low, and out of reset, `ppm_o` equals `pol_i` (the idle level) and `frame_req_o` is 0.
- R2: The tick counter advances once every `CLK_DIV` clocks. A pulse of period P lasts P*`CLK_DIV` clocks, and an entry of value 0 behaves as a period of 1.
- R3: On the first clock with `run_i` high, a start interval of `BOOT_PERIOD` ticks begins. The line stays idle throughout it, and `frame_req_o` pulses on the tick where the count equals `BOOT_REQ`. If nothing is committed, the start interval repeats.
- R4: In a train, the line is inactive while count < 2*delay and active while count >= 2*delay. Active means `ppm_o` = !`pol_i`.
- R5: Entries play in address order 0, 1, … count-1, and entry k sets the period of the k-th pulse of the train.
- R6: The delay compare value is captured from `delay_i` when a train is adopted. Changes to `delay_i` during the train have no effect on it.
- R7: `frame_req_o` is high for exactly one clock, on the tick where the count of the last entry equals (period − `LEAD_TICKS`). If period <= `LEAD_TICKS`, the request comes at count 0 instead.
- R8: Writes go to the bank that is not playing. A committed train is adopted only when the last entry of the current train (or of the start interval) ends. Writes made while a train plays do not alter that train.
- R9: With no pending commit, the last entry repeats with the same compare value, and a request is raised on every repetition.
- R10: A commit whose count is 0 or greater than `DEPTH` is ignored.
- R11: `pol_i` inverts the line at once, both in idle and in a train.
- R12: Dropping `run_i` returns the generator to idle one clock later. A later rise of `run_i` starts again with the start interval, and a pending commit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Generation enable |
| pol_i | input | 1 | 0: active level high; 1: active level low |
| delay_i | input | DLY_W | Pulse delay in microseconds (compare = 2*delay ticks) |
| wr_en_i | input | 1 | Write strobe for a period entry |
| wr_addr_i | input | $clog2(DEPTH) | Entry address in the non-playing bank |
| wr_data_i | input | PER_W | Period in ticks |
| commit_i | input | 1 | Commit the written bank |
| commit_cnt_i | input | $clog2(DEPTH+1) | Entry count of the committed train |
| ppm_o | output | 1 | PPM line |
| frame_req_o | output | 1 | One-clock request to prepare the next train |

## Verification
The bench builds the block with `CLK_DIV`=2, `DEPTH`=4, `LEAD_TICKS`=6, `BOOT_PERIOD`=40 and `BOOT_REQ`=30. These values shrink the start interval and the gaps to a few dozen clocks, so a single run covers many train swaps, repeats of the last entry, and a last entry shorter than the lead time. A depth of 4 with a 3-bit count port lets the bench try an over-range commit count. With a divider of 2, an off-by-one in the prescaler shows up as a shifted edge.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BOOT  = 2'd1,
        PH_TRAIN = 2'd2
    } ppm_phase_e;

    typedef struct packed {
        logic tick;
        logic pulse_end;
        logic last;
        logic adopt;
    } seq_evt_t;

    // Count at which the request fires within the last entry.
    function automatic int unsigned lead_point(int unsigned period, int unsigned lead);
        return (period > lead) ? (period - lead) : 0;
    endfunction

    function automatic bit count_legal(int unsigned cnt, int unsigned depth);
        return (cnt != 0) && (cnt <= depth);
    endfunction

endpackage

// File: rtl/ppm_tick_gen.sv
module ppm_tick_gen #(
    parameter int CLK_DIV = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic tick_o
);
    generate
        if (CLK_DIV <= 1) begin : g_direct
            assign tick_o = en_i;
        end else begin : g_div
            localparam int PRE_W = $clog2(CLK_DIV);
            localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_DIV - 1);
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || !en_i)
                    pre_q <= '0;
                else if (pre_q == PRE_MAX)
                    pre_q <= '0;
                else
                    pre_q <= pre_q + 1'b1;
            end

            assign tick_o = en_i && (pre_q == PRE_MAX);

            a_r2_pre_range: assert property (@(posedge clk) disable iff (rst)
                pre_q <= PRE_MAX);
            a_r2_pre_step: assert property (@(posedge clk) disable iff (rst)
                (en_i && !tick_o) |=> (pre_q == $past(pre_q) + 1'b1));
        end
    endgenerate
endmodule

// File: rtl/ppm_period_bank.sv
module ppm_period_bank #(
    parameter int DEPTH = 8,
    parameter int PER_W = 16,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [IW-1:0]    wr_addr_i,
    input  logic [PER_W-1:0] wr_data_i,
    input  logic             swap_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [PER_W-1:0] rd_data_o
);
    logic             play_q;
    logic [PER_W-1:0] mem_q [2][DEPTH];

    always_ff @(posedge clk) begin
        if (rst)
            play_q <= 1'b0;
        else if (swap_i)
            play_q <= ~play_q;
    end

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            for (genvar e = 0; e < DEPTH; e++) begin : g_ent
                always_ff @(posedge clk) begin
                    if (rst)
                        mem_q[b][e] <= '0;
                    else if (wr_en_i && (play_q != 1'(b)) && (int'(wr_addr_i) == e))
                        mem_q[b][e] <= wr_data_i;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        for (int e = 0; e < DEPTH; e++)
            if (int'(rd_idx_i) == e)
                rd_data_o = mem_q[play_q][e];
    end

    a_r8_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !swap_i |=> $stable(play_q));
    a_r8_play_untouched: assert property (@(posedge clk) disable iff (rst)
        (!swap_i && !$isunknown(rd_idx_i)) |=> (mem_q[play_q][$past(rd_idx_i)] == $past(rd_data_o)) || ($past(rd_idx_i) != rd_idx_i));
endmodule

// File: rtl/ppm_seq.sv
module ppm_seq
    import ppm_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int PER_W       = 16,
    parameter int DLY_W       = 10,
    parameter int LEAD_TICKS  = 4000,
    parameter int BOOT_PERIOD = 45000,
    parameter int BOOT_REQ    = 40000,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             commit_i,
    input  logic [CW-1:0]    commit_cnt_i,
    input  logic [PER_W-1:0] rd_data_i,
    output logic             tick_en_o,
    output logic [IW-1:0]    rd_idx_o,
    output logic             swap_o,
    output logic             active_o,
    output logic             frame_req_o
);
    localparam logic [PER_W-1:0] BOOT_PER_V = PER_W'(BOOT_PERIOD);
    localparam logic [PER_W-1:0] BOOT_REQ_V = PER_W'(BOOT_REQ);

    ppm_phase_e       phase_q;
    logic [PER_W-1:0] cnt_q;
    logic [IW-1:0]    idx_q;
    logic [CW-1:0]    len_q;
    logic [PER_W-1:0] cmp_q;
    logic             pend_q;
    logic [CW-1:0]    pend_len_q;

    logic [PER_W-1:0] period_now;
    logic [PER_W-1:0] req_pt;
    logic             commit_ok;
    seq_evt_t         ev;

    assign period_now = (phase_q == PH_BOOT) ? BOOT_PER_V : rd_data_i;
    assign req_pt     = (phase_q == PH_BOOT) ? BOOT_REQ_V
                      : PER_W'(lead_point(int'(period_now), LEAD_TICKS));
    assign commit_ok  = commit_i && count_legal(int'(commit_cnt_i), DEPTH);

    always_comb begin
        ev.tick      = tick_i;
        ev.pulse_end = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period_now};
        ev.last      = (phase_q == PH_BOOT) ||
                       ((phase_q == PH_TRAIN) && (CW'(idx_q) == len_q - 1'b1));
        ev.adopt     = ev.tick && ev.pulse_end && ev.last && (pend_q || commit_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_len_q <= '0;
        end else begin
            if (commit_ok)
                pend_len_q <= commit_cnt_i;
            if (ev.adopt)
                pend_q <= 1'b0;
            else if (commit_ok)
                pend_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            len_q   <= '0;
            cmp_q   <= '0;
        end else if (!run_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            phase_q <= PH_BOOT;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else if (ev.tick) begin
            if (ev.pulse_end) begin
                cnt_q <= '0;
                if (ev.adopt) begin
                    phase_q <= PH_TRAIN;
                    idx_q   <= '0;
                    len_q   <= commit_ok ? commit_cnt_i : pend_len_q;
                    cmp_q   <= PER_W'({delay_i, 1'b0});
                end else if (!ev.last) begin
                    idx_q <= idx_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick_en_o   = run_i && (phase_q != PH_IDLE);
    assign rd_idx_o    = idx_q;
    assign swap_o      = ev.adopt;
    assign active_o    = (phase_q == PH_TRAIN) && (cnt_q >= cmp_q);
    assign frame_req_o = ev.tick && ev.last && (cnt_q == req_pt);

    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && period_now != '0) |-> (cnt_q < period_now));
    a_r3_boot_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BOOT) |-> !active_o);
    a_r6_cmp_hold: assert property (@(posedge clk) disable iff (rst)
        !swap_o |=> $stable(cmp_q));
    a_r7_req_on_tick: assert property (@(posedge clk) disable iff (rst)
        frame_req_o |-> (tick_i && !$isunknown(cnt_q)));
    a_r7_req_single: assert property (@(posedge clk) disable iff (rst)
        frame_req_o |=> !frame_req_o);
    a_r8_swap_at_end: assert property (@(posedge clk) disable iff (rst)
        swap_o |=> (phase_q == PH_TRAIN && cnt_q == '0 && idx_q == '0));
    a_r5_idx_range: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TRAIN) |-> (CW'(idx_q) < len_q));
    a_r12_stop: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/ppm_train_gen.sv
module ppm_train_gen
    import ppm_pkg::*;
#(
    parameter int CLK_DIV     = 24,
    parameter int PER_W       = 16,
    parameter int DEPTH       = 8,
    parameter int DLY_W       = 10,
    parameter int LEAD_TICKS  = 4000,
    parameter int BOOT_PERIOD = 45000,
    parameter int BOOT_REQ    = 40000,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             pol_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             wr_en_i,
    input  logic [IW-1:0]    wr_addr_i,
    input  logic [PER_W-1:0] wr_data_i,
    input  logic             commit_i,
    input  logic [CW-1:0]    commit_cnt_i,
    output logic             ppm_o,
    output logic             frame_req_o
);
    logic             tick;
    logic             tick_en;
    logic [IW-1:0]    rd_idx;
    logic [PER_W-1:0] rd_data;
    logic             swap;
    logic             active;

    ppm_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    ppm_period_bank #(.DEPTH(DEPTH), .PER_W(PER_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .swap_i    (swap),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    ppm_seq #(
        .DEPTH       (DEPTH),
        .PER_W       (PER_W),
        .DLY_W       (DLY_W),
        .LEAD_TICKS  (LEAD_TICKS),
        .BOOT_PERIOD (BOOT_PERIOD),
        .BOOT_REQ    (BOOT_REQ)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .run_i        (run_i),
        .tick_i       (tick),
        .delay_i      (delay_i),
        .commit_i     (commit_i),
        .commit_cnt_i (commit_cnt_i),
        .rd_data_i    (rd_data),
        .tick_en_o    (tick_en),
        .rd_idx_o     (rd_idx),
        .swap_o       (swap),
        .active_o     (active),
        .frame_req_o  (frame_req_o)
    );

    assign ppm_o = active ^ pol_i;

    a_r1_idle_line: assert property (@(posedge clk) disable iff (rst)
        $past(!run_i) && !run_i |-> (ppm_o == pol_i && !frame_req_o));
    a_r11_pol_flip: assert property (@(posedge clk) disable iff (rst)
        ($stable(active) && $changed(pol_i)) |-> $changed(ppm_o));
endmodule

// File: tb/sim_ppm_train_gen.sv
module sim_ppm_train_gen;
    localparam int CLK_HALF = 5;
    localparam int DIV   = 2;
    localparam int PW    = 16;
    localparam int DEP   = 4;
    localparam int DW    = 8;
    localparam int LEAD  = 6;
    localparam int BPER  = 40;
    localparam int BREQ  = 30;
    localparam int IW    = 2;
    localparam int CW    = 3;

    logic clk = 0, rst = 1, run = 0, pol = 0;
    logic [DW-1:0] delay = 0;
    logic wr_en = 0, commit = 0;
    logic [IW-1:0] wr_addr = 0;
    logic [PW-1:0] wr_data = 0;
    logic [CW-1:0] commit_cnt = 0;
    logic ppm, req;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    string tag = "R1";

    ppm_train_gen #(.CLK_DIV(DIV), .PER_W(PW), .DEPTH(DEP), .DLY_W(DW),
        .LEAD_TICKS(LEAD), .BOOT_PERIOD(BPER), .BOOT_REQ(BREQ)) u0 (
        .clk(clk), .rst(rst), .run_i(run), .pol_i(pol), .delay_i(delay),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .commit_i(commit), .commit_cnt_i(commit_cnt),
        .ppm_o(ppm), .frame_req_o(req));

    always #CLK_HALF clk = ~clk;

    // behavioural reference model
    int m_phase, m_pre, m_cnt, m_idx, m_len, m_cmp, m_pend, m_plen, m_act;
    int bank [2][DEP];

    task automatic m_view(output int per, output bit tk, output bit last, output int rpt);
        per  = (m_phase == 1) ? BPER : bank[m_act][m_idx];
        tk   = run && (m_phase != 0) && (m_pre == DIV - 1);
        last = (m_phase == 1) || (m_phase == 2 && m_idx == m_len - 1);
        if (m_phase == 1) rpt = BREQ;
        else rpt = (per > LEAD) ? per - LEAD : 0;
    endtask

    always @(posedge clk) begin
        int per, rpt, wb, n_pre;
        bit tk, last, ok, pend_end, adopt;
        cyc++;
        if (rst) begin
            m_phase = 0; m_pre = 0; m_cnt = 0; m_idx = 0; m_len = 0; m_cmp = 0;
            m_pend = 0; m_plen = 0; m_act = 0;
            foreach (bank[b, e]) bank[b][e] = 0;
        end else begin
            m_view(per, tk, last, rpt);
            ok = commit && commit_cnt >= 1 && commit_cnt <= DEP;
            pend_end = (m_cnt + 1 >= per);
            adopt = tk && pend_end && last && (m_pend != 0 || ok);
            wb = 1 - m_act;
            if (!(run && m_phase != 0)) n_pre = 0;
            else n_pre = tk ? 0 : m_pre + 1;
            if (!run) begin
                m_phase = 0; m_cnt = 0; m_idx = 0;
            end else if (m_phase == 0) begin
                m_phase = 1; m_cnt = 0; m_idx = 0;
            end else if (tk) begin
                if (pend_end) begin
                    m_cnt = 0;
                    if (adopt) begin
                        m_phase = 2; m_idx = 0;
                        m_len = ok ? int'(commit_cnt) : m_plen;
                        m_cmp = 2 * int'(delay);
                        m_act = 1 - m_act;
                    end else if (!last) m_idx++;
                end else m_cnt++;
            end
            m_pre = n_pre;
            if (ok) m_plen = int'(commit_cnt);
            if (adopt) m_pend = 0; else if (ok) m_pend = 1;
            if (wr_en) bank[wb][wr_addr] = int'(wr_data);
        end
    end

    always @(negedge clk) begin
        int per, rpt;
        bit tk, last, e_req, e_ppm;
        if (!rst && !done) begin
            m_view(per, tk, last, rpt);
            e_req = tk && last && (m_cnt == rpt);
            e_ppm = pol ^ (m_phase == 2 && m_cnt >= m_cmp);
            total++;
            if (ppm !== e_ppm) begin
                bad++;
                $display("FAIL %s ppm_o at cycle %0d actual=%0b expected=%0b", tag, cyc, ppm, e_ppm);
            end
            total++;
            if (req !== e_req) begin
                bad++;
                $display("FAIL %s frame_req_o at cycle %0d actual=%0b expected=%0b", tag, cyc, req, e_req);
            end
        end
    end

    task automatic check(input string t, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic wait_req();
        do @(negedge clk); while (req !== 1'b1);
    endtask

    task automatic gap_check(input string t, input int exp);
        int t0;
        wait_req();
        t0 = cyc;
        wait_req();
        check(t, cyc - t0, exp);
    endtask

    task automatic load(input int n, input int p0, input int p1, input int p2, input int p3, input int cnt);
        int p [4];
        p = '{p0, p1, p2, p3};
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1; wr_addr = IW'(i); wr_data = PW'(p[i]);
        end
        @(posedge clk); #1;
        wr_en = 0; commit = 1; commit_cnt = CW'(cnt);
        @(posedge clk); #1;
        commit = 0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        // R1 / R11: idle line
        tag = "R1";
        repeat (3) @(negedge clk);
        check("R1 idle ppm_o", ppm, 0);
        check("R1 idle frame_req_o", req, 0);
        @(posedge clk); #1 pol = 1;
        @(negedge clk);
        check("R11 idle ppm_o follows pol", ppm, 1);
        @(posedge clk); #1 pol = 0;
        // R2 R3: start interval repeats with no commit
        tag = "R3 start interval (R2 tick rate)";
        @(posedge clk); #1 run = 1;
        gap_check("R3 start-interval request spacing", BPER * DIV);
        // R4 R5: first train, delay 3 -> compare 6
        tag = "R5 train order (R4 compare)";
        delay = 3;
        load(4, 10, 14, 8, 30, 4);
        wait_req();
        tag = "R9 last entry repeat";
        gap_check("R9 repeat spacing of 30-tick gap", 30 * DIV);
        // R6: delay change during train is ignored
        tag = "R6 delay held";
        @(posedge clk); #1 delay = 2;
        repeat (150) @(posedge clk);
        // R8: writes while playing, new train adopted at end
        tag = "R8 bank swap";
        wait_req();
        load(3, 9, 9, 20, 0, 3);
        wait_req();
        wait_req();
        gap_check("R8 adopted train last entry spacing", 20 * DIV);
        // R10: illegal counts ignored
        tag = "R10 illegal commit";
        @(posedge clk); #1 commit = 1; commit_cnt = 0;
        @(posedge clk); #1 commit_cnt = 5;
        @(posedge clk); #1 commit = 0;
        gap_check("R10 count 0/5 ignored, spacing kept", 20 * DIV);
        gap_check("R10 still no swap", 20 * DIV);
        // R11: inverted polarity in a train
        tag = "R11 polarity";
        @(posedge clk); #1 pol = 1;
        repeat (120) @(posedge clk);
        // R7: last entry shorter than lead time
        tag = "R7 short last entry";
        wait_req();
        load(2, 12, 6, 0, 0, 2);
        wait_req();
        wait_req();
        gap_check("R7 request at count 0 of 6-tick entry", 6 * DIV);
        // R12: stop and restart
        tag = "R12 stop";
        @(posedge clk); #1 run = 0;
        @(posedge clk);
        @(negedge clk);
        check("R12 line idle after stop", ppm, 1);
        check("R12 no request after stop", req, 0);
        @(posedge clk); #1 run = 1;
        tag = "R12 restart";
        gap_check("R12 restart uses start interval", BPER * DIV);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule